// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a 52-bit physical address by reading up to four 64-bit translation entries from memory, one table per step. Each step takes a 9-bit slice of the virtual address as the entry index. The step either follows the entry's frame number to the next table or stops at a leaf that maps a 4KB, 2MB or 1GB page. Write and user permissions are combined across every entry visited and checked after each read, so a walk stops as soon as it is certain to fault.

A requester presents the virtual address with its write and user flags on a valid/ready handshake. The walker accepts one request at a time. It issues single-beat reads on a plain memory read port, waiting any number of cycles for each response. It reports the result with a one-cycle completion pulse that carries the physical address, the page size, the combined permissions and a fault cause.

Top module: `pt_walker`

## Requirements
- R1: Step k (k = 0..3) indexes its table with virtual bits [47-9k : 39-9k]. The byte address read is {table frame number, index, 3'b000}. The first step uses `root_pfn` as the frame number.
- R2: A request whose bits 63..47 are not all equal completes with fault cause 3 (non-canonical) in the cycle after acceptance, and no memory read is issued.
- R3: An entry with bit 0 clear ends the walk with fault cause 1 (not present). No further reads follow.
- R4: When an entry is present and not a leaf, bits 51..12 give the frame number of the next table.
- R5: A present entry with bit 7 set at step 1 ends the walk with size code 2 (1GB). The physical address is {entry[51:30], vaddr[29:0]}.
- R6: A present entry with bit 7 set at step 2 ends the walk with size code 1 (2MB). The physical address is {entry[51:21], vaddr[20:0]}.
- R7: The entry at step 3 is always a 4KB leaf (size code 0) with physical address {entry[51:12], vaddr[11:0]}, whatever its bit 7 holds. Bit 7 at step 0 is ignored.
- R8: After each present entry, the walk ends with fault cause 2 (permission) if a write is requested while the AND of bit 1 over the entries so far is 0. It also ends that way if a user access is requested while the AND of bit 2 so far is 0. No further reads follow.
- R9: On success, `done_writable` and `done_user` give the AND of bits 1 and 2 over all entries visited, and `done_noexec` gives the OR of bit 63 over them. `done_cause` is 0.
- R10: On any fault, `done_paddr`, `done_size`, `done_writable`, `done_user` and `done_noexec` are all zero.
- R11: `req_ready` is high only when idle. It is low from the cycle after acceptance until `done_valid`, and high again in the cycle after `done_valid`. `done_valid` is a one-cycle pulse.
- R12: Each read is a one-cycle `mem_rd_en` pulse, and its address holds until `mem_rsp_valid`. `done_valid` rises in the cycle after the final response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_pfn | input | 40 | Frame number of the top-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user privilege |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_rd_addr | output | 52 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| done_valid | output | 1 | One-cycle completion pulse |
| done_paddr | output | 52 | Translated physical address |
| done_size | output | 2 | Page size: 0 = 4KB, 1 = 2MB, 2 = 1GB |
| done_writable | output | 1 | Combined write permission |
| done_user | output | 1 | Combined user permission |
| done_noexec | output | 1 | Combined execute-disable |
| done_fault | output | 1 | Walk ended in a fault |
| done_cause | output | 2 | 0 none, 1 not present, 2 permission, 3 non-canonical |

## Verification
A walk that performs n reads, each answered e cycles after its request would earliest be served, finishes n·(2+e)+1 cycles after the accepting edge. A non-canonical request therefore completes after exactly one cycle. The bench counts falling edges from acceptance to `done_valid` and compares that count with the formula, using the number of reads its memory model saw. It reads all result ports on the same falling edge as the pulse. `req_ready` is checked one edge after acceptance and one edge after completion, and the logged read addresses are compared with the index arithmetic.

// File: rtl/pt_walker_pkg.sv
// Shared constants and types for the page table walker.
// Assumes 48-bit virtual and 52-bit physical addresses with 4KB base pages.
package pt_walker_pkg;
    localparam int VA_W    = 48;
    localparam int PA_W    = 52;
    localparam int ENTRY_W = 64;
    localparam int OFS_W   = 12;
    localparam int IDX_W   = 9;
    localparam int LEVELS  = 4;
    localparam int LVL_W   = $clog2(LEVELS);
    localparam int PFN_W   = PA_W - OFS_W;
    localparam int HI_W    = VA_W - OFS_W;
    localparam int TOP_W   = ENTRY_W - VA_W + 1;
    localparam int GIG_W   = OFS_W + 2 * IDX_W;
    localparam int MEG_W   = OFS_W + IDX_W;

    localparam int B_PRESENT = 0;
    localparam int B_WRITE   = 1;
    localparam int B_USER    = 2;
    localparam int B_LEAF    = 7;
    localparam int B_NOEXEC  = 63;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} walk_state_e;
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0, CAUSE_ABSENT = 2'd1, CAUSE_PERM = 2'd2, CAUSE_NONCANON = 2'd3
    } fault_cause_e;
    typedef enum logic [1:0] {PG_4K = 2'd0, PG_2M = 2'd1, PG_1G = 2'd2} page_size_e;
endpackage

// File: rtl/pt_va_canon.sv
// Canonical-form check: the upper address bits must all copy bit 47.
// Assumes the caller passes bits 63..47 only.
module pt_va_canon
    import pt_walker_pkg::*;
(
    input  logic [TOP_W-1:0] va_top,
    output logic             va_ok
);
    // All ones or all zeros means a proper sign extension.
    always_comb va_ok = (&va_top) | ~(|va_top);
endmodule

// File: rtl/pt_va_index.sv
// Selects the 9-bit table index for the current walk step.
// Assumes step 0 uses the most significant slice of bits 47..12.
module pt_va_index
    import pt_walker_pkg::*;
(
    input  logic [HI_W-1:0]  va_hi,
    input  logic [LVL_W-1:0] lvl,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] slice [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = va_hi[HI_W-1-g*IDX_W -: IDX_W];
    end

    // Pick the slice of the active step.
    always_comb idx = slice[lvl];
endmodule

// File: rtl/pt_entry_eval.sv
// Decodes one translation entry in the context of the walk so far:
// presence, leaf detection per step, combined permissions and the leaf address.
// Assumes acc_* carry the combined permissions of earlier steps.
module pt_entry_eval
    import pt_walker_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic [LVL_W-1:0]   lvl,
    input  logic [GIG_W-1:0]   va_lo,
    input  logic               acc_w,
    input  logic               acc_u,
    input  logic               acc_nx,
    input  logic               want_write,
    input  logic               want_user,
    output logic               present,
    output logic               perm_bad,
    output logic               is_leaf,
    output page_size_e         size,
    output logic               new_w,
    output logic               new_u,
    output logic               new_nx,
    output logic [PFN_W-1:0]   next_pfn,
    output logic [PA_W-1:0]    leaf_pa
);
    logic unused_entry_bits;
    assign unused_entry_bits = ^{entry[ENTRY_W-2:PA_W], entry[OFS_W-1:B_LEAF+1], entry[B_LEAF-1:B_USER+1]};

    // Fold this entry's permission bits into the running set.
    always_comb begin
        present  = entry[B_PRESENT];
        new_w    = acc_w & entry[B_WRITE];
        new_u    = acc_u & entry[B_USER];
        new_nx   = acc_nx | entry[B_NOEXEC];
        perm_bad = (want_write & ~new_w) | (want_user & ~new_u);
        next_pfn = entry[PA_W-1:OFS_W];
    end

    // Leaf decision, page size and physical address by step.
    always_comb begin
        is_leaf = 1'b0;
        size    = PG_4K;
        leaf_pa = {entry[PA_W-1:OFS_W], va_lo[OFS_W-1:0]};
        case (lvl)
            LVL_W'(1): if (entry[B_LEAF]) begin
                is_leaf = 1'b1;
                size    = PG_1G;
                leaf_pa = {entry[PA_W-1:GIG_W], va_lo};
            end
            LVL_W'(2): if (entry[B_LEAF]) begin
                is_leaf = 1'b1;
                size    = PG_2M;
                leaf_pa = {entry[PA_W-1:MEG_W], va_lo[MEG_W-1:0]};
            end
            LVL_W'(3): is_leaf = 1'b1;
            default:   is_leaf = 1'b0;
        endcase
    end
endmodule

// File: rtl/pt_walker.sv
// Four-step translation walker. Accepts one request, checks its canonical
// form, reads one entry per step, stops on a leaf, an absent entry or a
// failed permission check, and reports the result with a one-cycle pulse.
// Assumes the memory answers each read exactly once with mem_rsp_valid.
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PFN_W-1:0]    root_pfn,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ENTRY_W-1:0]  req_vaddr,
    input  logic                req_write,
    input  logic                req_user,
    output logic                mem_rd_en,
    output logic [PA_W-1:0]     mem_rd_addr,
    input  logic                mem_rsp_valid,
    input  logic [ENTRY_W-1:0]  mem_rsp_data,
    output logic                done_valid,
    output logic [PA_W-1:0]     done_paddr,
    output logic [1:0]          done_size,
    output logic                done_writable,
    output logic                done_user,
    output logic                done_noexec,
    output logic                done_fault,
    output logic [1:0]          done_cause
);
    walk_state_e       state_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [VA_W-1:0]   va_q;
    logic              wr_q, us_q;
    logic [PFN_W-1:0]  tbl_pfn_q;
    logic              acc_w_q, acc_u_q, acc_nx_q;
    logic [PA_W-1:0]   res_pa_q;
    page_size_e        res_sz_q;
    logic              res_w_q, res_u_q, res_nx_q, res_flt_q;
    fault_cause_e      res_cause_q;

    logic              va_ok;
    logic [IDX_W-1:0]  walk_idx;
    logic              ent_present, ent_perm_bad, ent_leaf;
    page_size_e        ent_size;
    logic              ent_w, ent_u, ent_nx;
    logic [PFN_W-1:0]  ent_next_pfn;
    logic [PA_W-1:0]   ent_leaf_pa;

    pt_va_canon u_canon (
        .va_top (req_vaddr[ENTRY_W-1:VA_W-1]),
        .va_ok  (va_ok)
    );

    pt_va_index u_index (
        .va_hi (va_q[VA_W-1:OFS_W]),
        .lvl   (lvl_q),
        .idx   (walk_idx)
    );

    pt_entry_eval u_eval (
        .entry      (mem_rsp_data),
        .lvl        (lvl_q),
        .va_lo      (va_q[GIG_W-1:0]),
        .acc_w      (acc_w_q),
        .acc_u      (acc_u_q),
        .acc_nx     (acc_nx_q),
        .want_write (wr_q),
        .want_user  (us_q),
        .present    (ent_present),
        .perm_bad   (ent_perm_bad),
        .is_leaf    (ent_leaf),
        .size       (ent_size),
        .new_w      (ent_w),
        .new_u      (ent_u),
        .new_nx     (ent_nx),
        .next_pfn   (ent_next_pfn),
        .leaf_pa    (ent_leaf_pa)
    );

    // Port outputs derived from the state and the result registers.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_rd_en     = (state_q == ST_ISSUE);
        mem_rd_addr   = {tbl_pfn_q, walk_idx, 3'b000};
        done_valid    = (state_q == ST_RESP);
        done_paddr    = res_pa_q;
        done_size     = res_sz_q;
        done_writable = res_w_q;
        done_user     = res_u_q;
        done_noexec   = res_nx_q;
        done_fault    = res_flt_q;
        done_cause    = res_cause_q;
    end

    // Walk sequencing and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            lvl_q       <= '0;
            va_q        <= '0;
            wr_q        <= 1'b0;
            us_q        <= 1'b0;
            tbl_pfn_q   <= '0;
            acc_w_q     <= 1'b0;
            acc_u_q     <= 1'b0;
            acc_nx_q    <= 1'b0;
            res_pa_q    <= '0;
            res_sz_q    <= PG_4K;
            res_w_q     <= 1'b0;
            res_u_q     <= 1'b0;
            res_nx_q    <= 1'b0;
            res_flt_q   <= 1'b0;
            res_cause_q <= CAUSE_NONE;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    va_q      <= req_vaddr[VA_W-1:0];
                    wr_q      <= req_write;
                    us_q      <= req_user;
                    tbl_pfn_q <= root_pfn;
                    lvl_q     <= '0;
                    acc_w_q   <= 1'b1;
                    acc_u_q   <= 1'b1;
                    acc_nx_q  <= 1'b0;
                    if (!va_ok) begin
                        res_pa_q    <= '0;
                        res_sz_q    <= PG_4K;
                        res_w_q     <= 1'b0;
                        res_u_q     <= 1'b0;
                        res_nx_q    <= 1'b0;
                        res_flt_q   <= 1'b1;
                        res_cause_q <= CAUSE_NONCANON;
                        state_q     <= ST_RESP;
                    end else begin
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    if (!ent_present || ent_perm_bad) begin
                        res_pa_q    <= '0;
                        res_sz_q    <= PG_4K;
                        res_w_q     <= 1'b0;
                        res_u_q     <= 1'b0;
                        res_nx_q    <= 1'b0;
                        res_flt_q   <= 1'b1;
                        res_cause_q <= ent_present ? CAUSE_PERM : CAUSE_ABSENT;
                        state_q     <= ST_RESP;
                    end else if (ent_leaf) begin
                        res_pa_q    <= ent_leaf_pa;
                        res_sz_q    <= ent_size;
                        res_w_q     <= ent_w;
                        res_u_q     <= ent_u;
                        res_nx_q    <= ent_nx;
                        res_flt_q   <= 1'b0;
                        res_cause_q <= CAUSE_NONE;
                        state_q     <= ST_RESP;
                    end else begin
                        tbl_pfn_q <= ent_next_pfn;
                        acc_w_q   <= ent_w;
                        acc_u_q   <= ent_u;
                        acc_nx_q  <= ent_nx;
                        lvl_q     <= lvl_q + LVL_W'(1);
                        state_q   <= ST_ISSUE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready));

    a_r2_noncanon_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !va_ok) |=>
            (done_valid && done_fault && done_cause == 2'd3 && !mem_rd_en));

    a_r12_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || (state_q == ST_WAIT && !mem_rsp_valid)) |=> $stable(mem_rd_addr));

    a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault) |->
            (done_paddr == '0 && done_size == 2'd0 && !done_writable && !done_user && !done_noexec));

    a_r8_write_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault && wr_q) |-> done_writable);

    a_r8_user_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault && us_q) |-> done_user);
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] root_pfn = 40'h1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_rd_en;
    logic [51:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [51:0] done_paddr;
    logic [1:0]  done_size;
    logic        done_writable, done_user, done_noexec, done_fault;
    logic [1:0]  done_cause;

    pt_walker dut (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;

    // Memory model: entries keyed by byte address, absent keys read as zero.
    logic [63:0] pmem [logic [51:0]];
    int          extra_lat = 0;
    int          rsp_wait = 0;
    int          n_reads = 0;
    logic [51:0] rd_addr_l = '0;
    logic [51:0] addr_log [8];

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rsp_wait > 0) begin
            rsp_wait--;
            if (rsp_wait == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pmem.exists(rd_addr_l) ? pmem[rd_addr_l] : 64'h0;
            end
        end
        if (mem_rd_en) begin
            rd_addr_l = mem_rd_addr;
            rsp_wait  = 1 + extra_lat;
            if (n_reads < 8) addr_log[n_reads] = mem_rd_addr;
            n_reads++;
        end
    end

    task automatic put(input logic [51:0] base, input int idx, input logic [63:0] data);
        pmem[base + 52'(idx * 8)] = data;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mkva(input logic [8:0] i0, input logic [8:0] i1,
                                         input logic [8:0] i2, input logic [8:0] i3,
                                         input logic [11:0] off);
        logic [47:0] v;
        v = {i0, i1, i2, i3, off};
        return {{16{v[47]}}, v};
    endfunction

    typedef struct packed {
        logic [63:0] va;
        logic        wr;
        logic        us;
        logic        flt;
        logic [1:0]  cause;
        logic [51:0] pa;
        logic [1:0]  sz;
        logic        w;
        logic        u;
        logic        nx;
        logic [3:0]  reads;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        // R1 R7 R9: full 4KB walk, read then user write
        '{mkva(1,2,3,4,12'h567), 1'b0, 1'b0, 1'b0, 2'd0, 52'hABCDE567, 2'd0, 1'b1, 1'b1, 1'b0, 4'd4},
        '{mkva(1,2,3,4,12'h567), 1'b1, 1'b1, 1'b0, 2'd0, 52'hABCDE567, 2'd0, 1'b1, 1'b1, 1'b0, 4'd4},
        // R5: 1GB leaf at step 1
        '{mkva(1,7,9'h155,9'h0AA,12'h123), 1'b0, 1'b1, 1'b0, 2'd0,
          {22'h1, 30'({9'h155,9'h0AA,12'h123})}, 2'd2, 1'b1, 1'b1, 1'b0, 4'd2},
        // R6 R9: 2MB leaf at step 2 with execute-disable
        '{mkva(1,2,9,9'h1F3,12'hABC), 1'b1, 1'b0, 1'b0, 2'd0,
          {31'h93, 21'({9'h1F3,12'hABC})}, 2'd2 - 2'd1, 1'b1, 1'b1, 1'b1, 4'd3},
        // R7: bit 7 at step 3 still a 4KB page
        '{mkva(1,2,3,10,12'h0FF), 1'b0, 1'b0, 1'b0, 2'd0, 52'h555550FF, 2'd0, 1'b1, 1'b1, 1'b0, 4'd4},
        // R8: write to read-only leaf
        '{mkva(1,2,3,11,12'h010), 1'b1, 1'b0, 1'b1, 2'd2, 52'h0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd4},
        // R9: read of the same leaf reports no write permission
        '{mkva(1,2,3,11,12'h010), 1'b0, 1'b1, 1'b0, 2'd0, 52'h66666010, 2'd0, 1'b0, 1'b1, 1'b0, 4'd4},
        // R3: absent entry at step 1
        '{mkva(1,8,0,0,12'h0), 1'b0, 1'b0, 1'b1, 2'd1, 52'h0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd2},
        // R3: absent entry at step 0
        '{mkva(0,1,1,1,12'h0), 1'b0, 1'b0, 1'b1, 2'd1, 52'h0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd1},
        // R8: write stopped at step 0 by a read-only top entry
        '{mkva(5,0,0,9'h011,12'h222), 1'b1, 1'b1, 1'b1, 2'd2, 52'h0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd1},
        // R6 R4: read through that top entry to a 2MB leaf
        '{mkva(5,0,0,9'h011,12'h222), 1'b0, 1'b1, 1'b0, 2'd0,
          {31'h1, 21'({9'h011,12'h222})}, 2'd1, 1'b0, 1'b1, 1'b0, 4'd3},
        // R8: user access stopped at a supervisor-only top entry
        '{mkva(6,0,9'h1AB,9'h0CD,12'hEF0), 1'b0, 1'b1, 1'b1, 2'd2, 52'h0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd1},
        // R5 R9: supervisor write, 1GB leaf, user bit masked by the top entry
        '{mkva(6,0,9'h1AB,9'h0CD,12'hEF0), 1'b1, 1'b0, 1'b0, 2'd0,
          {22'h2, 30'({9'h1AB,9'h0CD,12'hEF0})}, 2'd2, 1'b1, 1'b0, 1'b0, 4'd2},
        // R2: upper bits zero with bit 47 set
        '{64'h0000_8000_0000_1000, 1'b0, 1'b0, 1'b1, 2'd3, 52'h0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0},
        // R2: upper bits ones with bit 47 clear
        '{64'hFFFF_0000_0000_0000, 1'b0, 1'b0, 1'b1, 2'd3, 52'h0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0},
        // R2 R3: proper high-half address is walked, top entry 511 absent
        '{mkva(9'h1FF,0,0,0,12'h0), 1'b0, 1'b0, 1'b1, 2'd1, 52'h0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd1},
        // R7: bit 7 at step 0 is ignored, walk continues to 4KB
        '{mkva(2,0,0,0,12'h345), 1'b0, 1'b0, 1'b0, 2'd0, 52'h0C345, 2'd0, 1'b1, 1'b1, 1'b0, 4'd4}
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 1, 16: return "R7";
            2, 12:    return "R5";
            3, 10:    return "R6";
            4:        return "R7";
            5, 9, 11: return "R8";
            6:        return "R9";
            7, 8, 15: return "R3";
            default:  return "R2";
        endcase
    endfunction

    logic [51:0] r_pa;
    logic [1:0]  r_sz, r_cause;
    logic        r_w, r_u, r_nx, r_flt, r_ready_mid, r_ready_after;
    int          r_cycles;

    // One request: drive, wait for the pulse, capture every result port there.
    task automatic do_walk(input logic [63:0] va, input logic wr, input logic us);
        @(negedge clk);
        check(req_ready == 1'b1, "R11", "ready before request", 64'(req_ready), 64'h1);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = us;
        n_reads = 0;
        @(negedge clk);
        req_valid = 1'b0;
        r_cycles = 1;
        r_ready_mid = req_ready;
        while (!done_valid && r_cycles < 1000) begin
            @(negedge clk);
            r_cycles++;
        end
        if (r_cycles >= 1000) check(1'b0, "R12", "walk timeout", 64'(r_cycles), 64'h0);
        r_pa = done_paddr; r_sz = done_size; r_w = done_writable; r_u = done_user;
        r_nx = done_noexec; r_flt = done_fault; r_cause = done_cause;
        @(negedge clk);
        r_ready_after = req_ready;
    endtask

    initial begin
        #(4ns * 200000);
        failures++;
        $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // Tables: top at 0x1000, present = 1, writable = 2, user = 4, leaf = 0x80.
        put(52'h1000, 1, 64'h2007);
        put(52'h1000, 5, 64'h6005);
        put(52'h1000, 6, 64'h7003);
        put(52'h1000, 2, 64'h9087);
        put(52'h2000, 2, 64'h3007);
        put(52'h2000, 7, 64'h4000_0087);
        put(52'h3000, 3, 64'h4007);
        put(52'h3000, 9, 64'h8000_0000_1260_0087);
        put(52'h4000, 4, 64'hABCDE007);
        put(52'h4000, 10, 64'h55555087);
        put(52'h4000, 11, 64'h66666005);
        put(52'h6000, 0, 64'h8007);
        put(52'h8000, 0, 64'h0020_0087);
        put(52'h7000, 0, 64'h8000_0087);
        put(52'h9000, 0, 64'hA007);
        put(52'hA000, 0, 64'hB007);
        put(52'hB000, 0, 64'hC007);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(req_ready == 1'b1, "R11", "reset ready", 64'(req_ready), 64'h1);
        check(done_valid == 1'b0, "R11", "reset done", 64'(done_valid), 64'h0);
        check(mem_rd_en == 1'b0, "R12", "reset read", 64'(mem_rd_en), 64'h0);

        for (int i = 0; i < NV; i++) begin
            do_walk(VECS[i].va, VECS[i].wr, VECS[i].us);
            check(r_flt == VECS[i].flt, tag_of(i), "fault", 64'(r_flt), 64'(VECS[i].flt));
            check(r_cause == VECS[i].cause, tag_of(i), "cause", 64'(r_cause), 64'(VECS[i].cause));
            // R10: fault vectors expect zero address, size and permissions
            check(r_pa == VECS[i].pa, tag_of(i), "paddr", 64'(r_pa), 64'(VECS[i].pa));
            check(r_sz == VECS[i].sz, tag_of(i), "size", 64'(r_sz), 64'(VECS[i].sz));
            check({r_w, r_u, r_nx} == {VECS[i].w, VECS[i].u, VECS[i].nx}, tag_of(i), "perms",
                  64'({r_w, r_u, r_nx}), 64'({VECS[i].w, VECS[i].u, VECS[i].nx}));
            check(n_reads == int'(VECS[i].reads), tag_of(i), "read count",
                  64'(n_reads), 64'(VECS[i].reads));
            // R12: completion due 2 cycles per read plus one
            check(r_cycles == 2 * int'(VECS[i].reads) + 1, "R12", "latency",
                  64'(r_cycles), 64'(2 * int'(VECS[i].reads) + 1));
            check(r_ready_mid == (VECS[i].reads == 4'd0 ? 1'b0 : 1'b0), "R11", "ready mid walk",
                  64'(r_ready_mid), 64'h0);
            check(r_ready_after == 1'b1, "R11", "ready after done", 64'(r_ready_after), 64'h1);
        end

        // R1 R4: entry addresses of the full walk
        do_walk(mkva(1,2,3,4,12'h567), 1'b0, 1'b0);
        check(addr_log[0] == 52'h1008, "R1", "step0 addr", 64'(addr_log[0]), 64'h1008);
        check(addr_log[1] == 52'h2010, "R1", "step1 addr", 64'(addr_log[1]), 64'h2010);
        check(addr_log[2] == 52'h3018, "R4", "step2 addr", 64'(addr_log[2]), 64'h3018);
        check(addr_log[3] == 52'h4020, "R4", "step3 addr", 64'(addr_log[3]), 64'h4020);

        // R12: slow memory, three extra wait cycles per read
        extra_lat = 3;
        do_walk(mkva(1,2,3,4,12'h567), 1'b0, 1'b0);
        check(r_cycles == 4 * 5 + 1, "R12", "slow latency", 64'(r_cycles), 64'(4 * 5 + 1));
        check(r_pa == 52'hABCDE567, "R12", "slow paddr", 64'(r_pa), 64'hABCDE567);
        check(addr_log[3] == 52'h4020, "R12", "slow step3 addr", 64'(addr_log[3]), 64'h4020);
        extra_lat = 0;

        // R11: reset during a walk returns to idle with no pulse
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = mkva(1,2,3,4,12'h0); req_write = 1'b0; req_user = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rsp_wait = 0;
        @(negedge clk);
        check(req_ready == 1'b1 && done_valid == 1'b0, "R11", "idle after reset",
              64'({req_ready, done_valid}), 64'h2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule